// File: doc/BRIEF.md
# Host-Port Memory Access Engine

This block lets an external host reach on-chip memory indirectly through three host-visible registers: control/status, address and data. The host first loads the address register. To read, it sets a fetch bit in the control register, polls a ready flag until the word has arrived, and then reads the data register. To write, it polls ready and writes the data register. The block then issues the store to memory.

A second host select code reaches the same data register with post-increment. A post-increment data read returns the current word, moves the address on by one 32-bit word and starts the next read at once. A run of sequential reads therefore needs only a poll of ready between accesses. A post-increment data write stores at the current address and then moves it on.

On the memory side there is a single-port request/acknowledge interface. The request is held until the memory acknowledges it, so any latency is accepted. While a transfer is outstanding, any host access other than a control read is dropped, and this sets a sticky error bit.

Top module: `hpmem_bridge`

## Requirements
- R1: After reset, the control register reads 0x1 (ready = bit 0 set, error = bit 2 clear), the address and data registers read 0, and `mem_req` is low.
- R2: A host write to select 0 with bit 1 set starts a memory read at the address register value. Ready (control bit 0) stays low until the acknowledge. The data register (select 3) then returns the word the memory supplied.
- R3: Once raised, `mem_req` stays high, with address, write enable and write data held stable, until `mem_ack` is sampled. Ready reads 1 in the cycle after that acknowledge edge and not before.
- R4: A host read at select 2 returns the data register, adds 4 to the address register and starts a memory read at the new address without any fetch write.
- R5: A host read at select 3 has no side effects: no memory request, the address is unchanged, and repeated reads return the same word until another fetch.
- R6: A host write to select 1 loads the address register with bits 1:0 forced to zero.
- R7: A host write at select 3 or 2 stores the value into the data register and issues a memory write at the current address, with ready low until the acknowledge. Select 2 also adds 4 to the address register.
- R8: While ready is low, every host access other than a control read is ignored, with no change to address, data or memory, and it sets the error flag (control bit 2).
- R9: Writing 1 to control bit 2 while ready clears the error flag. The fetch bit (bit 1) always reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select: 0 control, 1 address, 2 data with post-increment, 3 data |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Contents of the selected register (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a store, 0 for a load |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Load data, valid with mem_ack |

## Verification
The bench checks that a post-increment read chain returns consecutive words after polling alone. A design that prefetched the old address, or incremented after the fetch, would return a repeated or skipped word. It checks that ready rises exactly one cycle after the acknowledge and is still low in the acknowledge cycle. An off-by-one design would let the host read stale data. Accesses made during a slow transfer must leave the address and memory untouched and raise the error flag. A design that still acted on them would corrupt the address or memory. The remaining checks are the forced word alignment of the address, the fetch bit reading 0, and the plain data read leaving the memory interface idle.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL     = 2'd0,
    SEL_ADDR     = 2'd1,
    SEL_DATA_INC = 2'd2,
    SEL_DATA     = 2'd3
  } hsel_e;

  localparam int CTL_READY = 0;
  localparam int CTL_FETCH = 1;
  localparam int CTL_ERR   = 2;
  localparam int WORD_BYTES = 4;

  function automatic logic [31:0] word_next(logic [31:0] a);
    return a + 32'(WORD_BYTES);
  endfunction

  function automatic logic [31:0] word_align(logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction
endpackage

// File: rtl/hpm_decode.sv
module hpm_decode
  import hpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       wr,
  input  logic       rd,
  input  logic       fetch_bit,
  input  logic       errclr_bit,
  input  logic       ready,
  output logic       ev_fetch,
  output logic       ev_addr_wr,
  output logic       ev_data_wr,
  output logic       ev_wr_inc,
  output logic       ev_rd_inc,
  output logic       ev_err_clr,
  output logic       ev_reject
);
  logic ctrl_read, any_acc;
  assign ctrl_read = rd && !wr && (sel == SEL_CTRL);
  assign any_acc   = wr || rd;

  assign ev_reject  = !ready && any_acc && !ctrl_read;
  assign ev_fetch   = ready && wr && (sel == SEL_CTRL) && fetch_bit;
  assign ev_err_clr = ready && wr && (sel == SEL_CTRL) && errclr_bit;
  assign ev_addr_wr = ready && wr && (sel == SEL_ADDR);
  assign ev_data_wr = ready && wr && ((sel == SEL_DATA) || (sel == SEL_DATA_INC));
  assign ev_wr_inc  = ev_data_wr && (sel == SEL_DATA_INC);
  assign ev_rd_inc  = ready && rd && !wr && (sel == SEL_DATA_INC);

  // R8
  reject_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |-> !(ev_fetch || ev_addr_wr || ev_data_wr || ev_rd_inc || ev_err_clr));
  // R2
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_fetch, ev_data_wr, ev_rd_inc}));
endmodule

// File: rtl/hpm_seq.sv
module hpm_seq #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  output logic          ready,
  output logic          rd_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack
);
  logic busy_q, we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic done;

  assign done = busy_q && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      we_q    <= start_we;
      addr_q  <= start_addr;
      wdata_q <= start_wdata;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  assign ready     = !busy_q;
  assign rd_done   = done && !we_q;
  assign mem_req   = busy_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R3
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);
  // R8
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ready);
endmodule

// File: rtl/hpm_regs.sv
module hpm_regs
  import hpm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          ready,
  input  logic          ev_addr_wr,
  input  logic          ev_data_wr,
  input  logic          ev_wr_inc,
  input  logic          ev_rd_inc,
  input  logic          ev_err_clr,
  input  logic          ev_reject,
  input  logic          rd_done,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] addr_cur,
  output logic [AW-1:0] addr_inc,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          err_q;

  assign addr_cur = addr_q;
  assign addr_inc = AW'(word_next(32'(addr_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (ev_addr_wr)
        addr_q <= AW'(word_align(32'(wdata)));
      else if (ev_rd_inc || ev_wr_inc)
        addr_q <= addr_inc;
      if (ev_data_wr)
        data_q <= wdata;
      else if (rd_done)
        data_q <= rd_word;
      if (ev_reject)
        err_q <= 1'b1;
      else if (ev_err_clr)
        err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (hsel_e'(sel))
      SEL_CTRL: begin
        rdata[CTL_READY] = ready;
        rdata[CTL_ERR]   = err_q;
      end
      SEL_ADDR:     rdata = DW'(addr_q);
      default:      rdata = data_q;
    endcase
  end

  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_inc |=> (addr_q == AW'($past(addr_q) + AW'(WORD_BYTES))));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> err_q);
  // R8
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> ($stable(addr_q) && $stable(data_q)));
  // R6
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_wr |=> (addr_q[1:0] == 2'b00));
endmodule

// File: rtl/hpmem_bridge.sv
module hpmem_bridge
  import hpm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  logic ready, rd_done;
  logic ev_fetch, ev_addr_wr, ev_data_wr, ev_wr_inc, ev_rd_inc, ev_err_clr, ev_reject;
  logic start;
  logic [AW-1:0] addr_cur, addr_inc, start_addr;

  hpm_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sel(host_sel), .wr(host_wr), .rd(host_rd),
    .fetch_bit(host_wdata[CTL_FETCH]), .errclr_bit(host_wdata[CTL_ERR]),
    .ready(ready), .ev_fetch(ev_fetch), .ev_addr_wr(ev_addr_wr),
    .ev_data_wr(ev_data_wr), .ev_wr_inc(ev_wr_inc), .ev_rd_inc(ev_rd_inc),
    .ev_err_clr(ev_err_clr), .ev_reject(ev_reject)
  );

  assign start      = ev_fetch || ev_data_wr || ev_rd_inc;
  assign start_addr = ev_rd_inc ? addr_inc : addr_cur;

  hpm_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_we(ev_data_wr),
    .start_addr(start_addr), .start_wdata(host_wdata), .ready(ready),
    .rd_done(rd_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
  );

  hpm_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(host_sel), .wdata(host_wdata), .ready(ready),
    .ev_addr_wr(ev_addr_wr), .ev_data_wr(ev_data_wr), .ev_wr_inc(ev_wr_inc),
    .ev_rd_inc(ev_rd_inc), .ev_err_clr(ev_err_clr), .ev_reject(ev_reject),
    .rd_done(rd_done), .rd_word(mem_rdata), .addr_cur(addr_cur),
    .addr_inc(addr_inc), .rdata(host_rdata)
  );

  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |=> (mem_req && !mem_we && mem_addr == $past(addr_cur)));
  // R7
  store_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_wr |=> (mem_req && mem_we && mem_wdata == $past(host_wdata)));
endmodule

// File: tb/hpmem_bridge_tb.sv
`timescale 1ns/1ps
module hpmem_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  int checks = 0, errors = 0;
  int lat = 0, cnt = 0;
  bit finished = 0;
  logic [31:0] mem [16];

  always #2 clk = ~clk;

  hpmem_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] memval(int i);
    return 32'h1000_0000 ^ (32'(i) * 32'h0101_0301);
  endfunction

  // memory model: acknowledges after lat idle cycles
  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (cnt >= lat) begin
        cnt = 0;
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[5:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[5:2]];
      end else cnt++;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hwr(logic [1:0] s, logic [31:0] d);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hrd(logic [1:0] s, output logic [31:0] d);
    host_sel = s; host_rd = 1'b1; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic poll_ready();
    logic [31:0] v;
    int n = 0;
    do begin hrd(2'd0, v); n++; end while (!v[0] && n < 200);
  endtask

  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {16'h0000, 8'd0}, {16'h0004, 8'd1}, {16'h0020, 8'd3}, {16'h003C, 8'd0},
    {16'h0014, 8'd5}, {16'h0008, 8'd2}, {16'h0030, 8'd7}, {16'h0018, 8'd1}};

  initial begin
    logic [31:0] v, a;
    int n;
    for (int i = 0; i < 16; i++) mem[i] = memval(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    host_sel = 2'd0; #1 chk("R1 ctrl", host_rdata, 32'h1);
    host_sel = 2'd1; #1 chk("R1 addr", host_rdata, 32'h0);
    host_sel = 2'd3; #1 chk("R1 data", host_rdata, 32'h0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 table: address load, fetch, poll, read
    for (int i = 0; i < NV; i++) begin
      lat = int'(VEC[i][7:0]);
      hwr(2'd1, {16'd0, VEC[i][23:8]});
      hwr(2'd0, 32'h2);
      poll_ready();
      hrd(2'd3, v);
      chk($sformatf("R2 vec%0d", i), v, memval(int'(VEC[i][23:10])));
    end

    // R3 ready rises the cycle after acknowledge
    lat = 3;
    hwr(2'd0, 32'h2);
    host_sel = 2'd0;
    n = 0;
    while (!mem_ack && n < 50) begin @(negedge clk); #1; n++; end
    chk("R3 ready low at ack", {31'd0, host_rdata[0]}, 32'h0);
    @(negedge clk); #1;
    chk("R3 ready after ack", {31'd0, host_rdata[0]}, 32'h1);

    // R4 post-increment read chain
    lat = 2;
    hwr(2'd1, 32'h10);
    hwr(2'd0, 32'h2);
    for (int k = 4; k < 7; k++) begin
      poll_ready();
      hrd(2'd2, v);
      chk($sformatf("R4 chain word%0d", k), v, memval(k));
    end
    poll_ready();
    hrd(2'd1, a);
    chk("R4 addr advanced", a, 32'h1C);
    hrd(2'd3, v);
    chk("R4 prefetched next", v, memval(7));

    // R5 plain data read has no side effects
    hrd(2'd3, v);
    chk("R5 reread same", v, memval(7));
    chk("R5 no request", {31'd0, mem_req}, 32'h0);
    hrd(2'd1, a);
    chk("R5 addr kept", a, 32'h1C);

    // R6 address alignment
    hwr(2'd1, 32'h27);
    hrd(2'd1, a);
    chk("R6 aligned", a, 32'h24);

    // R7 writes
    lat = 1;
    hwr(2'd3, 32'hDEAD_BEEF);
    poll_ready();
    chk("R7 store plain", mem[9], 32'hDEAD_BEEF);
    hrd(2'd1, a);
    chk("R7 addr kept", a, 32'h24);
    hwr(2'd2, 32'h1234_5678);
    host_sel = 2'd0; #1;
    chk("R7 ready low", {31'd0, host_rdata[0]}, 32'h0);
    poll_ready();
    chk("R7 store inc", mem[9], 32'h1234_5678);
    hrd(2'd1, a);
    chk("R7 addr inc", a, 32'h28);

    // R8 accesses while busy are dropped
    lat = 8;
    hwr(2'd0, 32'h2);
    hrd(2'd0, v);
    chk("R9 fetch reads 0", {31'd0, v[1]}, 32'h0);
    hwr(2'd1, 32'h3C);
    hwr(2'd3, 32'h0BAD_0BAD);
    poll_ready();
    hrd(2'd0, v);
    chk("R8 err set", v, 32'h5);
    hrd(2'd1, a);
    chk("R8 addr unchanged", a, 32'h28);
    chk("R8 mem untouched", mem[15], memval(15));
    hrd(2'd3, v);
    chk("R8 data is fetched word", v, memval(10));

    // R9 error clear
    hwr(2'd0, 32'h4);
    hrd(2'd0, v);
    chk("R9 err cleared", v, 32'h1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule